// File: doc/BRIEF.md
# USB Endpoint Status and Write Interlock

This block is the register-side companion of a low-speed USB serial interface engine for a single endpoint. It holds a 4-bit endpoint mode, a receive byte count with its data-valid and data-toggle flags, and three PID status flags (Setup, In, Out). From the engine it takes token, data-phase, ACK, end-of-transaction and buffer-corrupted events. It decides whether each transaction suits the endpoint's configured mode, updates status only for valid transactions, and raises a one-cycle interrupt.

After any transaction in which an ACK changed hands, the mode and count registers become write-protected. Firmware removes the protection by reading either register once the transaction is over; a read made while a transaction is still open leaves the protection in place. This makes sure firmware has seen what the engine wrote before it can overwrite it.

Mode codes: 0 = disabled (accepts no token), 1 = control (Setup, In, Out), 2 = In only, 3 = Out only; codes 4 to 15 accept no token. Token kinds on `tok_kind`: 0 = Setup, 1 = In, 2 = Out, 3 = none.

Top module: `usb_ep_status_lock`

## Requirements
- R1: After reset the mode, count, flags and PID status read as zero, `irq` is low and `locked` is low.
- R2: A token the mode does not accept (Setup on a non-control endpoint, In on an Out-only endpoint, Out on an In-only endpoint, anything on mode 0) is ignored: no status change, no interrupt and no lock.
- R3: A received data packet is valid only if its byte count (CRC bytes included) is at most 10 and `rx_crc_ok` is high; a Setup or Out transaction with invalid data changes no status and raises no interrupt. An In transaction is valid when an ACK was transferred.
- R4: The Setup flag (read bit 7 of address 0) is set, and the In and Out flags cleared, in the cycle after `data_start` of an accepted Setup transaction, before the transaction ends.
- R5: The In flag (bit 6) or Out flag (bit 5) is set, and the other two PID flags cleared, only in the cycle after `eot` of a valid In or Out transaction.
- R6: Count (address 1, bits 3:0), data toggle (bit 6) and data-valid (bit 7, set to 1) are taken from the received packet at `eot` of a valid Setup or Out transaction, not at `data_done`.
- R7: `irq` is high for exactly one cycle, the cycle after `eot` of a valid transaction.
- R8: `buf_corrupt` raises `irq` in the next cycle; that transaction's data is then treated as invalid and its `eot` raises no second pulse.
- R9: `locked` (also read at address 0 bit 4) is set in the cycle after `eot` of any accepted transaction in which an ACK was transferred; CPU writes to either register are discarded while `locked` is high.
- R10: `locked` clears only after a CPU read (`cpu_rd`, either address) made with no transaction open; a read between token and `eot` leaves it set.
- R11: `cpu_rdata` shows address 0 as {setup, in, out, locked, mode[3:0]} and address 1 as {dval, dtog, 2'b00, count}; an unlocked write to address 0 sets the mode from bits 3:0, to address 1 sets dval, dtog and count from bits 7, 6 and 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_vld | input | 1 | Token received, opens a transaction |
| tok_kind | input | 2 | Token kind: 0 Setup, 1 In, 2 Out |
| data_start | input | 1 | Data packet phase begins |
| data_done | input | 1 | Data packet fully received |
| rx_count | input | 4 | Received byte count including CRC |
| rx_crc_ok | input | 1 | Packet passed all error checks |
| rx_toggle | input | 1 | Data toggle of the received packet |
| ack_xfer | input | 1 | ACK handshake transferred |
| eot | input | 1 | End of transaction |
| buf_corrupt | input | 1 | Receive buffer reported corrupted |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_addr | input | 1 | 0 mode/status, 1 count |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| irq | output | 1 | One-cycle interrupt pulse |
| locked | output | 1 | Mode and count write-protected |

## Verification
The hardest state to reach is a read that arrives while a fresh transaction is open on an endpoint that is still locked from the previous one: the bench closes an acknowledged In transaction, opens a second In token, issues the read between that token and its end, and only then reads again after `eot`. The corrupted-buffer path is also awkward, since the pulse must come early and the later end of the same transaction must stay silent; the bench injects the corruption between `data_done` and `eot` of an otherwise valid Out packet and watches both cycles.

// File: rtl/usb_ep_pkg.sv
// Shared types for the endpoint status block.
// Assumes a reduced mode set: off, control, in-only, out-only.
package usb_ep_pkg;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_NONE  = 2'd3
    } tok_e;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF  = 4'd0;
    localparam logic [MODE_W-1:0] MODE_CTRL = 4'd1;
    localparam logic [MODE_W-1:0] MODE_IN   = 4'd2;
    localparam logic [MODE_W-1:0] MODE_OUT  = 4'd3;

    // True when an endpoint in mode m takes part in a transaction opened by token t.
    function automatic logic ep_accepts(input logic [MODE_W-1:0] m, input tok_e t);
        case (t)
            TOK_SETUP: ep_accepts = (m == MODE_CTRL);
            TOK_IN:    ep_accepts = (m == MODE_CTRL) || (m == MODE_IN);
            TOK_OUT:   ep_accepts = (m == MODE_CTRL) || (m == MODE_OUT);
            default:   ep_accepts = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/usb_ep_txn_tracker.sv
// Follows one transaction from token to end, decides whether the endpoint
// takes part and whether the transaction is valid, and produces update events
// and the interrupt pulse.
// Assumes data_done arrives before eot and at most one token per transaction.
module usb_ep_txn_tracker
    import usb_ep_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              tok_vld,
    input  tok_e              tok_kind,
    input  logic              data_start,
    input  logic              data_done,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_crc_ok,
    input  logic              rx_toggle,
    input  logic              ack_xfer,
    input  logic              eot,
    input  logic              buf_corrupt,
    output logic              active,
    output tok_e              cur_tok,
    output logic              ev_setup,
    output logic              ev_done,
    output logic              ev_lock,
    output logic [CNT_W-1:0]  pkt_count,
    output logic              pkt_toggle,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_BYTES);

    logic acc_q, ack_q, data_ok_q, corrupt_q;
    logic ack_now, corrupt_now, in_txn, txn_ok;

    // Transaction context: opened by a token, closed by eot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            cur_tok    <= TOK_NONE;
            acc_q      <= 1'b0;
            ack_q      <= 1'b0;
            data_ok_q  <= 1'b0;
            corrupt_q  <= 1'b0;
            pkt_count  <= '0;
            pkt_toggle <= 1'b0;
        end else if (tok_vld) begin
            active    <= 1'b1;
            cur_tok   <= tok_kind;
            acc_q     <= ep_accepts(mode, tok_kind);
            ack_q     <= 1'b0;
            data_ok_q <= 1'b0;
            corrupt_q <= 1'b0;
        end else if (eot) begin
            active <= 1'b0;
        end else if (active) begin
            if (ack_xfer)    ack_q     <= 1'b1;
            if (buf_corrupt) corrupt_q <= 1'b1;
            if (data_done) begin
                data_ok_q  <= rx_crc_ok && (rx_count <= CNT_LIMIT);
                pkt_count  <= rx_count;
                pkt_toggle <= rx_toggle;
            end
        end
    end

    // Validity of the current transaction, counting events that land on eot itself.
    always_comb begin
        ack_now     = ack_q || ack_xfer;
        corrupt_now = corrupt_q || buf_corrupt;
        in_txn      = active && acc_q;
        txn_ok      = (cur_tok == TOK_IN) ? ack_now : (data_ok_q && !corrupt_now);
        ev_setup    = data_start && in_txn && (cur_tok == TOK_SETUP);
        ev_done     = eot && in_txn && txn_ok;
        ev_lock     = eot && in_txn && ack_now;
    end

    // Interrupt pulse: one cycle after a corruption report or a valid completion.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= buf_corrupt || (ev_done && !corrupt_q);
    end

    p_setup_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && tok_kind == TOK_SETUP && mode != MODE_CTRL) |=> !ev_setup && !ev_done)
        else $error("R2: setup accepted by non-control endpoint");

    p_corrupt_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_corrupt |=> irq)
        else $error("R8: no interrupt after buffer corruption");

    p_irq_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !corrupt_q) |=> irq)
        else $error("R7: no interrupt after valid completion");

endmodule

// File: rtl/usb_ep_write_lock.sv
// Write interlock for the mode and count registers. Set at the end of an
// acknowledged transaction, cleared by a CPU read made outside a transaction.
// Assumes ev_lock is only raised in a cycle where the transaction is active.
module usb_ep_write_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_lock,
    input  logic cpu_rd,
    input  logic active,
    output logic locked
);

    // Lock flag: set wins because the read qualifier excludes open transactions.
    always_ff @(posedge clk) begin
        if (!rst_n)                         locked <= 1'b0;
        else if (ev_lock)                   locked <= 1'b1;
        else if (cpu_rd && !active)         locked <= 1'b0;
    end

    p_lock_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lock |=> locked)
        else $error("R9: lock not set after acknowledged transaction");

    p_unlock_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(cpu_rd && !active))
        else $error("R10: lock cleared without an idle read");

endmodule

// File: rtl/usb_ep_status_regs.sv
// Mode, count and PID status registers with CPU write port and read mux.
// Engine updates take priority over a CPU write in the same cycle.
// Assumes CNT_W is at most 6 so the count fits the read layout.
module usb_ep_status_regs
    import usb_ep_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              ev_setup,
    input  logic              ev_done,
    input  tok_e              cur_tok,
    input  logic [CNT_W-1:0]  pkt_count,
    input  logic              pkt_toggle,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [MODE_W-1:0] mode,
    output logic [7:0]        cpu_rdata
);

    localparam int PAD_W = 6 - CNT_W;

    logic [CNT_W-1:0] count_q;
    logic dval_q, dtog_q;
    logic pid_setup, pid_in, pid_out;
    logic wr_ok;

    assign wr_ok = cpu_wr && !locked;

    // Mode register: CPU-owned, protected by the interlock.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mode <= MODE_OFF;
        else if (wr_ok && !cpu_addr)  mode <= cpu_wdata[MODE_W-1:0];
    end

    // Count and flags: engine update at a valid data-carrying end, else CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            dval_q  <= 1'b0;
            dtog_q  <= 1'b0;
        end else if (ev_done && cur_tok != TOK_IN) begin
            count_q <= pkt_count;
            dval_q  <= 1'b1;
            dtog_q  <= pkt_toggle;
        end else if (wr_ok && cpu_addr) begin
            count_q <= cpu_wdata[CNT_W-1:0];
            dval_q  <= cpu_wdata[7];
            dtog_q  <= cpu_wdata[6];
        end
    end

    // PID status: Setup at data phase start, In and Out at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_setup <= 1'b0;
            pid_in    <= 1'b0;
            pid_out   <= 1'b0;
        end else if (ev_setup) begin
            pid_setup <= 1'b1;
            pid_in    <= 1'b0;
            pid_out   <= 1'b0;
        end else if (ev_done && cur_tok == TOK_IN) begin
            pid_setup <= 1'b0;
            pid_in    <= 1'b1;
            pid_out   <= 1'b0;
        end else if (ev_done && cur_tok == TOK_OUT) begin
            pid_setup <= 1'b0;
            pid_in    <= 1'b0;
            pid_out   <= 1'b1;
        end
    end

    // Read mux for the two register addresses.
    always_comb begin
        if (!cpu_addr) cpu_rdata = {pid_setup, pid_in, pid_out, locked, mode};
        else           cpu_rdata = {dval_q, dtog_q, {PAD_W{1'b0}}, count_q};
    end

    p_locked_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cpu_wr && !cpu_addr) |=> $stable(mode))
        else $error("R9: mode written while locked");

    p_setup_at_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_setup) |-> $past(ev_setup))
        else $error("R4: setup flag set outside data phase start");

    p_in_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_in) |-> $past(ev_done))
        else $error("R5: in flag set outside transaction end");

    p_out_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_out) |-> $past(ev_done))
        else $error("R5: out flag set outside transaction end");

    p_count_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_done && !wr_ok) |=> $stable(count_q))
        else $error("R6: count changed without end or write");

endmodule

// File: rtl/usb_ep_status_lock.sv
// Top of the endpoint status block: ties the transaction tracker, the
// status registers and the write interlock together.
// Assumes all engine inputs are single-cycle pulses in the clk domain.
module usb_ep_status_lock
    import usb_ep_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_vld,
    input  logic [1:0]       tok_kind,
    input  logic             data_start,
    input  logic             data_done,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_crc_ok,
    input  logic             rx_toggle,
    input  logic             ack_xfer,
    input  logic             eot,
    input  logic             buf_corrupt,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             irq,
    output logic             locked
);

    logic [MODE_W-1:0] mode;
    logic              active, ev_setup, ev_done, ev_lock, pkt_toggle;
    tok_e              cur_tok;
    logic [CNT_W-1:0]  pkt_count;

    usb_ep_txn_tracker #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .tok_vld    (tok_vld),
        .tok_kind   (tok_e'(tok_kind)),
        .data_start (data_start),
        .data_done  (data_done),
        .rx_count   (rx_count),
        .rx_crc_ok  (rx_crc_ok),
        .rx_toggle  (rx_toggle),
        .ack_xfer   (ack_xfer),
        .eot        (eot),
        .buf_corrupt(buf_corrupt),
        .active     (active),
        .cur_tok    (cur_tok),
        .ev_setup   (ev_setup),
        .ev_done    (ev_done),
        .ev_lock    (ev_lock),
        .pkt_count  (pkt_count),
        .pkt_toggle (pkt_toggle),
        .irq        (irq)
    );

    usb_ep_status_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .ev_setup  (ev_setup),
        .ev_done   (ev_done),
        .cur_tok   (cur_tok),
        .pkt_count (pkt_count),
        .pkt_toggle(pkt_toggle),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mode      (mode),
        .cpu_rdata (cpu_rdata)
    );

    usb_ep_write_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_lock(ev_lock),
        .cpu_rd (cpu_rd),
        .active (active),
        .locked (locked)
    );

endmodule

// File: tb/usb_ep_status_lock_test.sv
// Directed bench: one task per scenario, each checking its own results.
module usb_ep_status_lock_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_vld = 0, data_start = 0, data_done = 0, rx_crc_ok = 0, rx_toggle = 0;
    logic       ack_xfer = 0, eot = 0, buf_corrupt = 0, cpu_wr = 0, cpu_rd = 0, cpu_addr = 0;
    logic [1:0] tok_kind = 2'd3;
    logic [3:0] rx_count = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq, locked;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    usb_ep_status_lock uut (
        .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_kind(tok_kind),
        .data_start(data_start), .data_done(data_done), .rx_count(rx_count),
        .rx_crc_ok(rx_crc_ok), .rx_toggle(rx_toggle), .ack_xfer(ack_xfer),
        .eot(eot), .buf_corrupt(buf_corrupt), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .locked(locked)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Combinational look at a register without a read strobe.
    task automatic peek(input logic a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic cpu_write(input logic a, input logic [7:0] d);
        @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic a, output logic [7:0] d);
        @(negedge clk); cpu_rd = 1; cpu_addr = a; #1; d = cpu_rdata;
        @(negedge clk); cpu_rd = 0;
    endtask

    task automatic token(input logic [1:0] k);
        @(negedge clk); tok_vld = 1; tok_kind = k;
        @(negedge clk); tok_vld = 0; tok_kind = 2'd3;
    endtask

    task automatic pulse_start();
        @(negedge clk); data_start = 1;
        @(negedge clk); data_start = 0;
    endtask

    task automatic pkt(input logic [3:0] c, input logic ok, input logic tg);
        @(negedge clk); data_done = 1; rx_count = c; rx_crc_ok = ok; rx_toggle = tg;
        @(negedge clk); data_done = 0;
    endtask

    task automatic ack();
        @(negedge clk); ack_xfer = 1;
        @(negedge clk); ack_xfer = 0;
    endtask

    task automatic end_txn();
        @(negedge clk); eot = 1;
        @(negedge clk); eot = 0;
    endtask

    task automatic corrupt();
        @(negedge clk); buf_corrupt = 1;
        @(negedge clk); buf_corrupt = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(0, d); check("R1 mode/status", d, 8'h00);
        peek(1, d); check("R1 count", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 locked", {7'd0, locked}, 8'd0);
    endtask

    task automatic t_cpu_access();
        logic [7:0] d;
        cpu_write(0, 8'h01);
        peek(0, d); check("R11 mode write", d, 8'h01);
        cpu_write(1, 8'h85);
        peek(1, d); check("R11 count write", d, 8'h85);
    endtask

    task automatic t_setup_valid();
        logic [7:0] d;
        token(2'd0);
        pulse_start();
        peek(0, d); check("R4 setup flag at data start", d, 8'h81);
        pkt(4'd8, 1, 0);
        peek(1, d); check("R6 count not yet taken", d, 8'h85);
        ack();
        end_txn();
        check("R7 irq after end", {7'd0, irq}, 8'd1);
        check("R9 locked after ack", {7'd0, locked}, 8'd1);
        peek(1, d); check("R6 count taken at end", d, 8'h88);
        peek(0, d); check("R9 status shows lock", d, 8'h91);
        @(negedge clk);
        check("R7 irq single cycle", {7'd0, irq}, 8'd0);
        cpu_write(0, 8'h03);
        peek(0, d); check("R9 mode write discarded", d, 8'h91);
        cpu_write(1, 8'h00);
        peek(1, d); check("R9 count write discarded", d, 8'h88);
        cpu_read(0, d);
        check("R10 idle read unlocks", {7'd0, locked}, 8'd0);
    endtask

    task automatic t_out_invalid();
        logic [7:0] d;
        token(2'd2);
        pkt(4'd11, 1, 1);
        end_txn();
        check("R3 count 11 no irq", {7'd0, irq}, 8'd0);
        peek(1, d); check("R3 count 11 no update", d, 8'h88);
        peek(0, d); check("R3 count 11 no pid", d, 8'h81);
        token(2'd2);
        pkt(4'd4, 0, 1);
        end_txn();
        check("R3 bad crc no irq", {7'd0, irq}, 8'd0);
        peek(1, d); check("R3 bad crc no update", d, 8'h88);
    endtask

    task automatic t_in_and_busy_read();
        logic [7:0] d;
        token(2'd1);
        ack();
        peek(0, d); check("R5 in flag not before end", d, 8'h81);
        end_txn();
        check("R7 irq after in", {7'd0, irq}, 8'd1);
        peek(0, d); check("R5 in flag at end", d, 8'h51);
        token(2'd1);
        cpu_read(0, d);
        check("R10 read during txn keeps lock", {7'd0, locked}, 8'd1);
        end_txn();
        check("R3 in without ack no irq", {7'd0, irq}, 8'd0);
        cpu_read(1, d);
        check("R10 read after end unlocks", {7'd0, locked}, 8'd0);
        peek(0, d); check("R10 status after unlock", d, 8'h41);
    endtask

    task automatic t_out_only();
        logic [7:0] d;
        cpu_write(0, 8'h03);
        token(2'd1); ack(); end_txn();
        check("R2 in on out-only no irq", {7'd0, irq}, 8'd0);
        check("R2 in on out-only no lock", {7'd0, locked}, 8'd0);
        peek(0, d); check("R2 in on out-only status", d, 8'h43);
        token(2'd0); pulse_start();
        peek(0, d); check("R2 setup on out-only flag", d, 8'h43);
        pkt(4'd3, 1, 0); ack(); end_txn();
        check("R2 setup on out-only no irq", {7'd0, irq}, 8'd0);
        peek(1, d); check("R2 setup on out-only count", d, 8'h88);
        token(2'd2); pkt(4'd10, 1, 1); ack(); end_txn();
        check("R3 count 10 irq", {7'd0, irq}, 8'd1);
        peek(0, d); check("R5 out flag", d, 8'h33);
        peek(1, d); check("R3 count 10 taken", d, 8'hCA);
        cpu_read(0, d);
    endtask

    task automatic t_corrupt();
        logic [7:0] d;
        token(2'd2); pkt(4'd2, 1, 0);
        corrupt();
        check("R8 irq after corrupt", {7'd0, irq}, 8'd1);
        @(negedge clk);
        check("R8 irq single cycle", {7'd0, irq}, 8'd0);
        end_txn();
        check("R8 no second irq at end", {7'd0, irq}, 8'd0);
        peek(1, d); check("R8 corrupted data dropped", d, 8'hCA);
    endtask

    task automatic t_in_only_and_off();
        logic [7:0] d;
        cpu_write(0, 8'h02);
        token(2'd2); pkt(4'd5, 1, 0); ack(); end_txn();
        check("R2 out on in-only no irq", {7'd0, irq}, 8'd0);
        peek(0, d); check("R2 out on in-only status", d, 8'h22);
        peek(1, d); check("R2 out on in-only count", d, 8'hCA);
        cpu_write(0, 8'h00);
        token(2'd1); ack(); end_txn();
        check("R2 off mode no irq", {7'd0, irq}, 8'd0);
        check("R2 off mode no lock", {7'd0, locked}, 8'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cpu_access();
        t_setup_valid();
        t_out_invalid();
        t_in_and_busy_read();
        t_out_only();
        t_corrupt();
        t_in_only_and_off();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule